// File: doc/BRIEF.md
# Processing-Element Loop Sequencer

This block sequences the configuration memory of one processing element. It keeps the current configuration address (the program counter), a pair of hardware loop bounds and a one-bit predicate. Each cycle it looks at the decoded instruction word. From that word and its own state it chooses the address for the next cycle.

One branch instruction does two jobs. It moves the program counter to a destination, and it loads the start and end addresses of a hardware loop. From then on, whenever the counter sits on the loop end, it goes back to the loop start by itself, so the loop body needs no further branch. The same branch clears the predicate. The memory-unit trigger bit of the instruction word leaves the block unchanged on its own output, for branches and for all other instructions.

Top module: `pe_loop_sequencer`

## Requirements
- R1: After reset (active-low `rst_n`, asynchronous), `cfg_addr`, `pred`, loop start and loop end are all 0. A reset also clears any bounds loaded earlier, so with no branch the address holds at 0.
- R2: An instruction is a branch only when its opcode field `instr[58:54]` equals `OP_JUMP` (default 18); any other opcode value is not a branch. A branch with flag bit `instr[50]` set makes the next `cfg_addr` equal to `instr[49:45]`.
- R3: A branch with flag bit `instr[50]` clear makes the next `cfg_addr` equal to its new loop start `instr[44:40]`, whatever `instr[49:45]` holds.
- R4: A branch loads loop start from `instr[44:40]` and loop end from `instr[39:35]`. The loop then repeats from end back to start with no further branch.
- R5: A non-branch cycle in which `cfg_addr` equals the loop end makes the next `cfg_addr` equal to the loop start.
- R6: In any other non-branch cycle, `cfg_addr` increments by one modulo 32 (31 is followed by 0).
- R7: A branch takes priority over the loop-end wrap when both apply in the same cycle.
- R8: A branch clears `pred` on the next edge, even when `pred_load` is high in the same cycle.
- R9: In a non-branch cycle with `pred_load` high, `pred` takes `pred_value` on the next edge; otherwise it holds.
- R10: `agu_trig` equals `instr[59]` combinationally, for branches and non-branches alike.
- R11: The bound fields of a non-branch instruction have no effect: the loop bounds keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 64 | Decoded instruction word of the current cycle |
| pred_load | input | 1 | Write enable for the predicate |
| pred_value | input | 1 | Value written to the predicate |
| cfg_addr | output | 5 | Current configuration-memory address |
| pred | output | 1 | Predicate register |
| agu_trig | output | 1 | Memory-unit trigger bit passed through from the instruction |

## Verification
The bench uses the default parameters: a 5-bit counter, a 64-bit word, branch opcode 18 and the explicit-destination flag enabled. With these values it can reach both ends of the 32-entry address space. It runs loops whose end lies below their start, so the counter passes through the modulo-32 wrap before it reaches the loop end. It also runs a branch that falls on the loop end in the same cycle, and an opcode one bit away from the branch code.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

  typedef enum logic [1:0] {
    NXT_STEP = 2'd0,
    NXT_WRAP = 2'd1,
    NXT_JUMP = 2'd2
  } nxt_src_e;

  // Priority: branch first, then loop-end wrap, then plain step.
  function automatic nxt_src_e choose_src(input logic is_jump, input logic at_end);
    if (is_jump) return NXT_JUMP;
    if (at_end)  return NXT_WRAP;
    return NXT_STEP;
  endfunction

endpackage

// File: rtl/pe_seq_decode.sv
module pe_seq_decode #(
  parameter int unsigned INSTR_W   = 64,
  parameter int unsigned PC_W      = 5,
  parameter int unsigned OP_W      = 5,
  parameter int unsigned OP_LSB    = 54,
  parameter logic [OP_W-1:0] OP_JUMP = 5'd18,
  parameter int unsigned TRIG_POS  = 59,
  parameter int unsigned DSTV_POS  = 50,
  parameter int unsigned DST_LSB   = 45,
  parameter int unsigned START_LSB = 40,
  parameter int unsigned END_LSB   = 35,
  parameter bit          EXPLICIT_DST_EN = 1'b1
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_jump,
  output logic [PC_W-1:0]    jump_dst,
  output logic [PC_W-1:0]    new_start,
  output logic [PC_W-1:0]    new_end,
  output logic               agu_trig
);
  localparam int unsigned OP_MSB    = OP_LSB + OP_W - 1;
  localparam int unsigned DST_MSB   = DST_LSB + PC_W - 1;
  localparam int unsigned START_MSB = START_LSB + PC_W - 1;
  localparam int unsigned END_MSB   = END_LSB + PC_W - 1;

  logic [PC_W-1:0] field_dst;
  logic            unused_instr_bits;

  assign is_jump   = (instr[OP_MSB:OP_LSB] == OP_JUMP);
  assign field_dst = instr[DST_MSB:DST_LSB];
  assign new_start = instr[START_MSB:START_LSB];
  assign new_end   = instr[END_MSB:END_LSB];
  assign agu_trig  = instr[TRIG_POS];
  assign unused_instr_bits = ^instr;

  generate
    if (EXPLICIT_DST_EN) begin : g_dst_flag
      assign jump_dst = instr[DSTV_POS] ? field_dst : new_start;
    end else begin : g_dst_field
      assign jump_dst = field_dst;
    end
  endgenerate

endmodule

// File: rtl/pe_seq_bounds.sv
module pe_seq_bounds #(
  parameter int unsigned PC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_jump,
  input  logic [PC_W-1:0] new_start,
  input  logic [PC_W-1:0] new_end,
  input  logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] loop_start,
  output logic            at_end
);
  logic [PC_W-1:0] loop_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_start <= '0;
      loop_end   <= '0;
    end else if (is_jump) begin
      loop_start <= new_start;
      loop_end   <= new_end;
    end
  end

  assign at_end = (pc == loop_end);

  // R11 / R4: bounds only move on a branch
  a_r11_bounds_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !is_jump |=> ($stable(loop_start) && $stable(loop_end)));

  // R4: a branch captures both fields
  a_r4_bounds_load: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |=> (loop_start == $past(new_start) && loop_end == $past(new_end)));

endmodule

// File: rtl/pe_seq_pc.sv
module pe_seq_pc
  import pe_seq_pkg::*;
#(
  parameter int unsigned PC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_jump,
  input  logic [PC_W-1:0] jump_dst,
  input  logic            at_end,
  input  logic [PC_W-1:0] loop_start,
  output logic [PC_W-1:0] pc
);
  nxt_src_e        src;
  logic [PC_W-1:0] pc_next;

  function automatic logic [PC_W-1:0] step_pc(input logic [PC_W-1:0] cur);
    return PC_W'(cur + 1'b1);
  endfunction

  assign src = choose_src(is_jump, at_end);

  always_comb begin
    unique case (src)
      NXT_JUMP: pc_next = jump_dst;
      NXT_WRAP: pc_next = loop_start;
      default:  pc_next = step_pc(pc);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  // R2 / R7: a branch wins over everything
  a_r7_jump_first: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |=> (pc == $past(jump_dst)));

  // R5: loop-end wrap
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_jump && at_end) |=> (pc == $past(loop_start)));

  // R6: plain step
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_jump && !at_end) |=> (pc == PC_W'($past(pc) + 1'b1)));

endmodule

// File: rtl/pe_seq_pred.sv
module pe_seq_pred (
  input  logic clk,
  input  logic rst_n,
  input  logic is_jump,
  input  logic pred_load,
  input  logic pred_value,
  output logic pred
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pred <= 1'b0;
    else if (is_jump)   pred <= 1'b0;
    else if (pred_load) pred <= pred_value;
  end

  // R8: branch clears predicate
  a_r8_jump_clears: assert property (@(posedge clk) disable iff (!rst_n)
    is_jump |=> !pred);

  // R9: write and hold
  a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_jump && pred_load) |=> (pred == $past(pred_value)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_jump && !pred_load) |=> $stable(pred));

endmodule

// File: rtl/pe_loop_sequencer.sv
module pe_loop_sequencer #(
  parameter int unsigned INSTR_W   = 64,
  parameter int unsigned PC_W      = 5,
  parameter int unsigned OP_W      = 5,
  parameter int unsigned OP_LSB    = 54,
  parameter logic [OP_W-1:0] OP_JUMP = 5'd18,
  parameter int unsigned TRIG_POS  = 59,
  parameter int unsigned DSTV_POS  = 50,
  parameter int unsigned DST_LSB   = 45,
  parameter int unsigned START_LSB = 40,
  parameter int unsigned END_LSB   = 35,
  parameter bit          EXPLICIT_DST_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               pred_load,
  input  logic               pred_value,
  output logic [PC_W-1:0]    cfg_addr,
  output logic               pred,
  output logic               agu_trig
);
  logic            is_jump;
  logic [PC_W-1:0] jump_dst;
  logic [PC_W-1:0] new_start;
  logic [PC_W-1:0] new_end;
  logic [PC_W-1:0] loop_start;
  logic            at_end;

  pe_seq_decode #(
    .INSTR_W(INSTR_W), .PC_W(PC_W), .OP_W(OP_W), .OP_LSB(OP_LSB),
    .OP_JUMP(OP_JUMP), .TRIG_POS(TRIG_POS), .DSTV_POS(DSTV_POS),
    .DST_LSB(DST_LSB), .START_LSB(START_LSB), .END_LSB(END_LSB),
    .EXPLICIT_DST_EN(EXPLICIT_DST_EN)
  ) u_decode (
    .instr     (instr),
    .is_jump   (is_jump),
    .jump_dst  (jump_dst),
    .new_start (new_start),
    .new_end   (new_end),
    .agu_trig  (agu_trig)
  );

  pe_seq_bounds #(.PC_W(PC_W)) u_bounds (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_jump    (is_jump),
    .new_start  (new_start),
    .new_end    (new_end),
    .pc         (cfg_addr),
    .loop_start (loop_start),
    .at_end     (at_end)
  );

  pe_seq_pc #(.PC_W(PC_W)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_jump    (is_jump),
    .jump_dst   (jump_dst),
    .at_end     (at_end),
    .loop_start (loop_start),
    .pc         (cfg_addr)
  );

  pe_seq_pred u_pred (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_jump    (is_jump),
    .pred_load  (pred_load),
    .pred_value (pred_value),
    .pred       (pred)
  );

  // R1: reset values seen on the first active edge after release
  a_r1_reset_pc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_addr == '0 && !pred));

endmodule

// File: tb/pe_loop_sequencer_bench.sv
module pe_loop_sequencer_bench;
  localparam int unsigned NV = 18;
  localparam logic [4:0] OPJ = 5'd18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] instr = '0;
  logic        pred_load = 1'b0;
  logic        pred_value = 1'b0;
  logic [4:0]  cfg_addr;
  logic        pred;
  logic        agu_trig;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pe_loop_sequencer u_pe_loop_sequencer (
    .clk(clk), .rst_n(rst_n), .instr(instr), .pred_load(pred_load),
    .pred_value(pred_value), .cfg_addr(cfg_addr), .pred(pred), .agu_trig(agu_trig)
  );

  // row: {jmp, dstv, dst, start, end, trig, pld, pval, exp_pc, exp_pred}
  function automatic logic [25:0] mk(input logic j, input logic v, input int d,
      input int s, input int e, input logic t, input logic pl, input logic pv,
      input int epc, input logic ep);
    return {j, v, 5'(d), 5'(s), 5'(e), t, pl, pv, 5'(epc), ep};
  endfunction

  localparam logic [25:0] VEC [NV] = '{
    mk(0,0, 0, 0, 0,0,1,1,  0,1),  // R5 at reset bounds, R9
    mk(1,1, 3, 2, 5,1,1,1,  3,0),  // R2, R8
    mk(0,0, 0, 0, 0,0,0,0,  4,0),  // R6
    mk(0,1,31, 9, 9,1,0,0,  5,0),  // R11 junk fields
    mk(0,0, 0, 0, 0,0,1,1,  2,1),  // R5, R4
    mk(0,0, 0, 0, 0,0,0,0,  3,1),
    mk(0,0, 0, 0, 0,1,0,0,  4,1),
    mk(0,0, 0, 0, 0,0,0,0,  5,1),
    mk(1,0,20, 7, 8,0,0,0,  7,0),  // R3, R7
    mk(0,0, 0, 0, 0,0,0,0,  8,0),
    mk(0,0, 0, 0, 0,0,0,0,  7,0),  // R4 repeat
    mk(1,1,30,29,31,1,0,0, 30,0),
    mk(0,0, 0, 0, 0,0,0,0, 31,0),
    mk(0,0, 0, 0, 0,0,0,0, 29,0),
    mk(1,1,31,31, 0,0,0,0, 31,0),
    mk(0,0, 0, 0, 0,0,0,0,  0,0),  // R6 modulo
    mk(0,0, 0, 0, 0,0,1,1, 31,1),
    mk(0,0, 0, 0, 0,0,1,0,  0,0)
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] op, input logic v, input logic [4:0] d,
      input logic [4:0] s, input logic [4:0] e, input logic t,
      input logic pl, input logic pv);
    instr = 64'hA000_0000_0000_0000 | 64'h0000_0005_5AA5_5AA5;
    instr[58:54] = op;
    instr[59]    = t;
    instr[50]    = v;
    instr[49:45] = d;
    instr[44:40] = s;
    instr[39:35] = e;
    pred_load    = pl;
    pred_value   = pv;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(5'd3, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 addr", cfg_addr, 0);
    check("R1 pred", pred, 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] r;
      r = VEC[i];
      drive(r[25] ? OPJ : 5'd3, r[24], r[23:19], r[18:14], r[13:9], r[8], r[7], r[6]);
      #1;
      check("R10 trig", agu_trig, r[8]);
      @(negedge clk);
      check($sformatf("R2-6 addr row %0d", i), cfg_addr, r[5:1]);
      check($sformatf("R8 R9 pred row %0d", i), pred, r[0]);
    end

    // R1: reset clears loaded bounds and predicate
    drive(OPJ, 1, 9, 9, 12, 0, 0, 0);
    @(negedge clk);
    drive(5'd3, 0, 0, 0, 0, 0, 1, 1);
    @(negedge clk);
    check("R1 pre-reset addr", cfg_addr, 10);
    check("R1 pre-reset pred", pred, 1);
    rst_n = 1'b0;
    drive(5'd3, 0, 0, 0, 0, 0, 0, 0);
    #1;
    check("R1 async addr", cfg_addr, 0);
    check("R1 async pred", pred, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 bounds cleared", cfg_addr, 0);

    // R2: opcode one bit away is not a branch
    drive(OPJ, 1, 4, 4, 10, 1, 0, 0);
    @(negedge clk);
    check("R2 jump", cfg_addr, 4);
    drive(OPJ ^ 5'd1, 1, 20, 1, 2, 0, 0, 0);
    #1;
    check("R10 trig low", agu_trig, 0);
    @(negedge clk);
    check("R2 near opcode", cfg_addr, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule